// File: doc/BRIEF.md
# Delta-Sigma Referenced Successive-Approximation Converter

This block measures an analog level with one external comparator and a loop that is otherwise all digital. The comparator's negative input gets a reference made on chip: a first-order delta-sigma modulator drives a one-bit pin, and an external RC network filters that pin to a DC voltage. The analog signal goes to the comparator's positive input. The comparator's decision comes back as a single input bit.

A bit-search sequencer runs a binary search. It starts at mid-scale. For each trial it loads the code into the modulator and waits a programmable number of cycles so the filtered reference can settle. It then samples the synchronised comparator bit and keeps or clears that bit. Code 0 maps to 0 V and the full-scale code maps to the I/O supply. The resolution is chosen per conversion. Each finished code goes into a small result queue that a consumer drains through a read port. A sticky flag records results that were lost because the queue was full.

Top module: `ds_sar_adc`

## Requirements
- R1: Holding rst_n low for one rising edge or more gives these values: busy=0, done=0, dac_out=0, fifo_empty=1, fifo_full=0, overflow=0, rd_valid=0 and rd_data=0.
- R2: The requested resolution res_bits is clamped into the range [4, MAX_BITS]. It is latched at the edge that accepts start and is used for the whole conversion.
- R3: A conversion of N bits runs exactly N trials, from the MSB down to the LSB. The first trial code is 2^(N-1). A trial bit is kept when the comparator reads 1 (analog at or above the reference) and cleared otherwise, and the next lower bit is then set. The result is right-aligned in rd_data, so a level L, measured in units of full scale / 2^MAX_BITS, gives floor(L / 2^(MAX_BITS-N)).
- R4: The modulator is an accumulator MAX_BITS+1 bits wide. Its carry drives dac_out through a register, and the trial code enters left-aligned to MAX_BITS bits. Over any 2^MAX_BITS cycles with a constant N-bit code C, dac_out is high exactly C*2^(MAX_BITS-N) times. While no conversion runs, the code is 0 and dac_out stays 0.
- R5: Each trial is held for settle_cycles+1 cycles. The comparator is then read through a two-flop synchronizer. From the accepting edge, done appears exactly N*(settle_cycles+1) edges later.
- R6: A start that arrives while busy=1 is ignored. The running conversion keeps its resolution, its result and its timing, and no extra result is queued.
- R7: done is high for exactly one cycle, at the edge that decides the last bit. busy falls at that same edge, and the result is written into the queue in that same cycle.
- R8: The queue holds FIFO_DEPTH (16) results in arrival order. A read with rd_en=1 on a non-empty queue gives the oldest entry on rd_data with rd_valid=1 one cycle later.
- R9: A read of an empty queue gives rd_data=0 and rd_valid=0 in the following cycle.
- R10: A result that arrives while fifo_full=1 is dropped and sets overflow. overflow stays set until ovf_clr is applied. If a drop and ovf_clr fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a conversion when idle |
| res_bits | input | $clog2(MAX_BITS+1) | Requested resolution in bits |
| settle_cycles | input | SETTLE_W | Settle wait per trial, minus one |
| comp_in | input | 1 | Comparator result, 1 = analog above reference |
| dac_out | output | 1 | One-bit modulator output to the RC filter |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse at end of a conversion |
| rd_en | input | 1 | Read request to the result queue |
| rd_data | output | MAX_BITS | Result read from the queue, right-aligned |
| rd_valid | output | 1 | rd_data holds a queued result |
| fifo_empty | output | 1 | Queue has no entries |
| fifo_full | output | 1 | Queue holds FIFO_DEPTH entries |
| ovf_clr | input | 1 | Clear the overflow flag |
| overflow | output | 1 | Sticky: a result was dropped |

## Verification
A wrong trial bit or a bad bit index in the sequencer shows up as a wrong code on rd_data. The error appears on the first read after that conversion ends, which is at most N*(settle_cycles+1)+2 cycles after start. A settle counter that is off by one, or a skipped trial, moves done away from its exact cycle, so it is visible at the end of every conversion. A broken modulator density biases the comparator and corrupts codes near step boundaries, so the sweep over every level at every resolution catches it. Queue pointer or count faults show up as results out of order, a wrong fifo_full or overflow edge, or a nonzero value from an empty read.

// File: rtl/ds_sar_pkg.sv
// Shared constants and types for the delta-sigma referenced converter.
// Assumes consumers also import the sequencer state type from here.
package ds_sar_pkg;
    localparam int MIN_BITS = 4;

    typedef enum logic {
        SQ_IDLE   = 1'b0,
        SQ_SETTLE = 1'b1
    } seq_state_t;
endpackage

// File: rtl/ds_modulator.sv
// First-order delta-sigma modulator: the accumulator wraps at 2^M and
// its carry is registered onto the one-bit output. Assumes the code is
// already left-aligned to M bits, so density = code / 2^M.
module ds_modulator #(
    parameter int M = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [M-1:0] code,
    output logic         dac_out
);
    logic [M-1:0] acc;
    logic [M:0]   sum;

    // Next accumulator value with its carry bit.
    always_comb sum = {1'b0, acc} + {1'b0, code};

    // Accumulate and register the carry as the pulse stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            dac_out <= 1'b0;
        end else begin
            acc     <= sum[M-1:0];
            dac_out <= sum[M];
        end
    end

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0) |=> !dac_out);
endmodule

// File: rtl/ds_bit_sync.sv
// Two-flop synchronizer for the asynchronous comparator bit.
// Assumes the input is a level that stays valid for many cycles.
module ds_bit_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic meta;

    // Shift the raw bit through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta   <= 1'b0;
            d_sync <= 1'b0;
        end else begin
            meta   <= d_async;
            d_sync <= meta;
        end
    end
endmodule

// File: rtl/ds_sar_seq.sv
// Binary-search sequencer. On an accepted start it latches the clamped
// resolution, tries mid-scale, and then waits settle+1 cycles per trial
// before it keeps or clears each bit. Assumes M >= 4 and a comparator
// bit that is already synchronised.
module ds_sar_seq
    import ds_sar_pkg::*;
#(
    parameter int M     = 16,
    parameter int SET_W = 16,
    localparam int RES_W = $clog2(M + 1),
    localparam int IDX_W = (M > 1) ? $clog2(M) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [RES_W-1:0] res_req,
    input  logic [SET_W-1:0] settle,
    input  logic             comp_s,
    output logic             busy,
    output logic             done,
    output logic [M-1:0]     code_out,
    output logic [M-1:0]     result
);
    localparam logic [RES_W-1:0] MINB = RES_W'(MIN_BITS);
    localparam logic [RES_W-1:0] MAXB = RES_W'(M);
    localparam logic [M-1:0]     ONE  = M'(1);

    seq_state_t       state;
    logic [RES_W-1:0] nbits;
    logic [RES_W-1:0] nb_req;
    logic [IDX_W-1:0] bitpos;
    logic [SET_W-1:0] cnt;
    logic [M-1:0]     trial;
    logic [M-1:0]     cur_mask;
    logic [M-1:0]     decided;

    // Clamp the requested resolution into the supported range.
    always_comb begin
        if (res_req < MINB)      nb_req = MINB;
        else if (res_req > MAXB) nb_req = MAXB;
        else                     nb_req = res_req;
    end

    // Keep or clear the bit under trial according to the comparator.
    always_comb begin
        cur_mask = ONE << bitpos;
        decided  = comp_s ? trial : (trial & ~cur_mask);
    end

    // Left-align the trial code for the modulator; zero while idle.
    always_comb code_out = trial << (MAXB - nbits);

    // Busy whenever a search is in progress.
    always_comb busy = (state == SQ_SETTLE);

    // Search state machine: settle countdown, then decide one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            nbits  <= MINB;
            bitpos <= '0;
            cnt    <= '0;
            trial  <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        nbits  <= nb_req;
                        trial  <= ONE << (nb_req - 1'b1);
                        bitpos <= IDX_W'(nb_req - 1'b1);
                        cnt    <= settle;
                        state  <= SQ_SETTLE;
                    end
                end
                SQ_SETTLE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (bitpos == '0) begin
                        result <= decided;
                        done   <= 1'b1;
                        trial  <= '0;
                        state  <= SQ_IDLE;
                    end else begin
                        trial  <= decided | (cur_mask >> 1);
                        bitpos <= bitpos - 1'b1;
                        cnt    <= settle;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(nbits));
    // R2
    res_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (nbits >= MINB && nbits <= MAXB));
endmodule

// File: rtl/ds_result_fifo.sv
// Result queue with a registered read port. A push while full is dropped
// and sets a sticky flag, and an empty read returns zero without valid.
// Assumes DEPTH is a power of two.
module ds_result_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = AW + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         rd_en,
    input  logic         ovf_clr,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic         empty,
    output logic         full,
    output logic         overflow
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] count;
    logic          do_push;
    logic          do_pop;

    // Occupancy flags and qualified operations.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        do_push = push && !full;
        do_pop  = rd_en && !empty;
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // Registered read port; zero and no strobe on an empty read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else if (do_pop) begin
            rd_data  <= mem[rptr];
            rd_valid <= 1'b1;
        end else begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end
    end

    // Sticky overflow; a drop wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)             overflow <= 1'b0;
        else if (push && full)  overflow <= 1'b1;
        else if (ovf_clr)       overflow <= 1'b0;
    end

    // R10
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> overflow);
    // R10
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);
    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> (!rd_valid && rd_data == '0));
    // R8
    read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !empty) |=> rd_valid);
endmodule

// File: rtl/ds_sar_adc.sv
// Top level: sequencer, modulator, comparator synchronizer and result
// queue. Assumes an external RC filter on dac_out that feeds the
// comparator's negative input, and settle_cycles held stable while busy.
module ds_sar_adc #(
    parameter int MAX_BITS   = 16,
    parameter int SETTLE_W   = 16,
    parameter int FIFO_DEPTH = 16,
    localparam int RES_W = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [RES_W-1:0]    res_bits,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                comp_in,
    output logic                dac_out,
    output logic                busy,
    output logic                done,
    input  logic                rd_en,
    output logic [MAX_BITS-1:0] rd_data,
    output logic                rd_valid,
    output logic                fifo_empty,
    output logic                fifo_full,
    input  logic                ovf_clr,
    output logic                overflow
);
    logic                comp_s;
    logic [MAX_BITS-1:0] dac_code;
    logic [MAX_BITS-1:0] result;

    ds_bit_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (comp_in),
        .d_sync  (comp_s)
    );

    ds_sar_seq #(.M(MAX_BITS), .SET_W(SETTLE_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .res_req  (res_bits),
        .settle   (settle_cycles),
        .comp_s   (comp_s),
        .busy     (busy),
        .done     (done),
        .code_out (dac_code),
        .result   (result)
    );

    ds_modulator #(.M(MAX_BITS)) u_mod (
        .clk     (clk),
        .rst_n   (rst_n),
        .code    (dac_code),
        .dac_out (dac_out)
    );

    ds_result_fifo #(.W(MAX_BITS), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (done),
        .push_data (result),
        .rd_en     (rd_en),
        .ovf_clr   (ovf_clr),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .overflow  (overflow)
    );
endmodule

// File: tb/ds_sar_adc_test.sv
`timescale 1ns/1ps
// Bench: a 6-bit configuration. An ideal filter is modelled as the count
// of dac_out ones over the last 64 cycles, and the comparator is driven
// from it. Every level is swept at every resolution.
module ds_sar_adc_test;
    localparam int MB = 6;
    localparam int SW = 8;
    localparam int DEP = 16;
    localparam int SETTLE = 72;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    res_bits = 3'd6;
    logic [SW-1:0] settle_cycles = SW'(SETTLE);
    logic          comp_in = 1'b0;
    logic          dac_out;
    logic          busy;
    logic          done;
    logic          rd_en = 1'b0;
    logic [MB-1:0] rd_data;
    logic          rd_valid;
    logic          fifo_empty;
    logic          fifo_full;
    logic          ovf_clr = 1'b0;
    logic          overflow;

    int   n_chk = 0;
    int   n_bad = 0;
    int   level = 0;
    logic [63:0] hist = '0;

    ds_sar_adc #(.MAX_BITS(MB), .SETTLE_W(SW), .FIFO_DEPTH(DEP)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .res_bits(res_bits),
        .settle_cycles(settle_cycles), .comp_in(comp_in), .dac_out(dac_out),
        .busy(busy), .done(done), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .ovf_clr(ovf_clr), .overflow(overflow)
    );

    always #4 clk = ~clk;

    // Ideal filter plus comparator: reference = ones in the last 64 samples.
    always @(negedge clk) begin
        hist    = {hist[62:0], dac_out};
        comp_in = (level >= $countones(hist));
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampn(int r);
        if (r < 4) return 4;
        if (r > MB) return MB;
        return r;
    endfunction

    task automatic run_conv(int req, int lvl, output int cyc);
        level    = lvl;
        res_bits = req[2:0];
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 1;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic read_one(output int d, output int v);
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
        d = int'(rd_data);
        v = int'(rd_valid);
    endtask

    // Convert, check the timing and the done width, then read and check the code.
    task automatic conv_and_check(string req, int r, int lvl);
        int cyc, d, v, n;
        n = clampn(r);
        run_conv(r, lvl, cyc);
        chk({req, " R5 cycles"}, cyc, n * (SETTLE + 1) + 1);
        @(negedge clk);
        chk("R7 done one cycle", int'(done), 0);
        read_one(d, v);
        chk({req, " R3 valid"}, v, 1);
        chk({req, " R3 code"}, d, lvl >> (MB - n));
    endtask

    initial begin
        #(8ns * 190000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cyc, d, v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 dac_out", int'(dac_out), 0);
        chk("R1 empty", int'(fifo_empty), 1);
        chk("R1 full", int'(fifo_full), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 rd_data", int'(rd_data), 0);

        // R4 idle: no pulses while no conversion runs
        repeat (20) @(negedge clk);
        chk("R4 idle dac_out", int'(dac_out), 0);

        // R3/R4 exhaustive sweep of levels at each resolution
        for (int n = 4; n <= MB; n++)
            for (int l = 0; l < 64; l++)
                conv_and_check("R3 sweep", n, l);

        // R2 clamping below and above the range
        for (int l = 0; l < 64; l += 5) conv_and_check("R2 low", 2, l);
        for (int l = 0; l < 64; l += 7) conv_and_check("R2 high", 7, l);
        conv_and_check("R2 zero", 0, 63);

        // R6 start while busy is ignored
        level = 45;
        res_bits = 3'd6;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 1;
        repeat (20) begin @(negedge clk); cyc++; end
        res_bits = 3'd4;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc++;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
        chk("R6 timing kept", cyc, 6 * (SETTLE + 1) + 1);
        @(negedge clk);
        chk("R6 busy after", int'(busy), 0);
        read_one(d, v);
        chk("R6 code kept", d, 45);
        read_one(d, v);
        chk("R6 no extra result", v, 0);
        chk("R9 empty data", d, 0);

        // R8/R10 fill, overflow, drain in order, then clear
        for (int i = 0; i < 17; i++) begin
            run_conv(4, i * 3, cyc);
            @(negedge clk);
            if (i == 15) begin
                chk("R8 full at depth", int'(fifo_full), 1);
                chk("R10 no ovf at depth", int'(overflow), 0);
            end
        end
        chk("R10 overflow set", int'(overflow), 1);
        for (int i = 0; i < 16; i++) begin
            read_one(d, v);
            chk("R8 order valid", v, 1);
            chk("R8 order data", d, (i * 3) >> 2);
        end
        chk("R8 empty after drain", int'(fifo_empty), 1);
        chk("R10 sticky", int'(overflow), 1);
        read_one(d, v);
        chk("R9 empty valid", v, 0);
        chk("R9 empty data", d, 0);
        @(negedge clk) ovf_clr = 1'b1;
        @(negedge clk) ovf_clr = 1'b0;
        chk("R10 cleared", int'(overflow), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule